// File: doc/BRIEF.md
# Dual Timebase Sweep Controller

This block sequences the horizontal sweeps of a sampled-display instrument. It counts time in sample-clock ticks and runs two timebases. The main timebase A sweeps a programmable number of positions and steps one position every `ratio` ticks. The faster timebase B steps one position every tick. Timebase A also sets a delay point, and B may begin only after that point. B then either starts at once or waits for its own delayed-trigger strobe.

Timebase A arms in one of two ways. In AUTO it free-runs when no trigger comes. In NORMAL it waits in standby for a trigger. A holdoff count blocks re-arming after each sweep. Four display modes decide how the two timebases reach the screen: the intensify flag marks the B interval on the A trace, and the display-select output chooses which ramp the display follows. The block produces digital ramp positions and flags only. Analog ramps, trigger comparators and drawing are left to other logic.

Top module: `sweep_timebase`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `aSweep`, `bSweep` and `intensify` are 0 and timebase A is armed. `dispSel` is 0 except in display mode 2, where it is 1.
- R2: With `autoMode`=0 (NORMAL), timebase A never free-runs. `aSweep` rises only in the cycle after a `trigStb` that is sampled while A is armed.
- R3: With `autoMode`=1 (AUTO) and no trigger, A starts by itself. `aSweep` rises `autoTimeout`+1 cycles after A becomes armed. A trigger that comes earlier starts the sweep in the next cycle.
- R4: During a sweep, `aPos` runs from 0 to `lenA`-1 and advances once every `ratio` cycles. The sweep lasts `lenA`*`ratio` cycles. A value of 0 in either field counts as 1. This holds for ratios up to 1000 and beyond.
- R5: When sweep A ends, with B not running, A stays idle for `holdoff`+1 cycles. Triggers in that window are ignored. A is then armed again.
- R6: The delay point is the first cycle in which `aPos` equals `delayPt`. With `bStartSel`=0, `bSweep` rises in the next cycle. If `delayPt` >= `lenA`, B does not run.
- R7: With `bStartSel`=1, B arms at the delay point. `bSweep` rises in the cycle after the first `dlyTrigStb` sampled while B is armed and A is still sweeping. A `dlyTrigStb` at or before the delay point is ignored.
- R8: If B is armed and no `dlyTrigStb` comes before sweep A ends, B is dropped for that sweep. It stays idle until the delay point of a later sweep.
- R9: While B runs, `bPos` counts from 0 to `lenB`-1, one step per cycle, for `lenB` cycles (0 counts as 1). B finishes even after sweep A has ended. A does not re-arm until B is done.
- R10: `dispMode`=1 (A intensified by B) sets `intensify` high exactly while A and B both sweep. In every other mode `intensify` is 0.
- R11: `dispSel` (0 selects A, 1 selects B) is 0 in modes 0 (A only) and 1, and 1 in mode 2 (B only). In mode 3 (mixed) it is 1 from the cycle after the delay point until B completes or is dropped, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigStb | input | 1 | Main trigger strobe |
| dlyTrigStb | input | 1 | Delayed-trigger strobe for timebase B |
| autoMode | input | 1 | 1 = AUTO, 0 = NORMAL |
| bStartSel | input | 1 | 0 = B starts at the delay point, 1 = B waits for the delayed trigger |
| dispMode | input | 2 | 0 A only, 1 A intensified by B, 2 B only, 3 mixed |
| ratio | input | RATIO_W | Ticks per A position |
| lenA | input | W | A sweep length in positions |
| delayPt | input | W | A position at which B may begin |
| lenB | input | W | B sweep length in ticks |
| holdoff | input | W | Idle ticks after a sweep before re-arming |
| autoTimeout | input | W | Armed idle ticks before an AUTO free-run |
| aSweep | output | 1 | Timebase A sweeping |
| bSweep | output | 1 | Timebase B sweeping |
| aPos | output | W | A ramp position |
| bPos | output | W | B ramp position |
| intensify | output | 1 | Brighten the A trace during B |
| dispSel | output | 1 | Display source, 0 = A, 1 = B |

## Verification
Some rules are checked on every cycle: in NORMAL mode a sweep needs a trigger, ramp positions change in single steps, B only begins while A sweeps, A never restarts while B runs, at least one idle cycle follows each A sweep, and the fixed display modes drive the intensify and select outputs correctly. Exact cycle counts for the free-run timeout, the holdoff window, the sweep lengths at large ratios, the point where B starts, early delayed triggers being ignored, and B being dropped when no delayed trigger comes can only be shown by the bench. The bench compares every output in every cycle against a behavioural model that tracks elapsed time, over random and directed episodes.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SWEEP = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    B_OFF  = 2'd0,
    B_WAIT = 2'd1,
    B_RUN  = 2'd2
  } bstate_e;

  typedef enum logic [1:0] {
    DM_A      = 2'd0,
    DM_INTENS = 2'd1,
    DM_B      = 2'd2,
    DM_MIX    = 2'd3
  } dmode_e;

  // control -> datapath
  typedef struct packed {
    logic aStart;
    logic aAdv;
    logic holdClr;
    logic holdInc;
    logic idleClr;
    logic idleInc;
    logic bStart;
    logic bAdv;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic aLast;
    logic dlyHit;
    logic bLast;
    logic holdDone;
    logic idleDone;
  } flag_t;

endpackage

// File: rtl/sweep_dp.sv
module sweep_dp
  import sweep_pkg::*;
#(
  parameter int W       = 16,
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [W-1:0]       lenA,
  input  logic [W-1:0]       delayPt,
  input  logic [W-1:0]       lenB,
  input  logic [W-1:0]       holdoff,
  input  logic [W-1:0]       autoTimeout,
  output flag_t              flg,
  output logic [W-1:0]       aPos,
  output logic [W-1:0]       bPos
);

  localparam int RW1 = RATIO_W + 1;
  localparam int W1  = W + 1;

  logic [RATIO_W-1:0] aPre;
  logic [W-1:0]       holdCnt;
  logic [W-1:0]       idleCnt;
  logic [RATIO_W-1:0] ratioEff;
  logic               preLast;
  logic               posLast;

  // a zero ratio behaves as one tick per position
  assign ratioEff = (ratio == '0) ? RATIO_W'(1) : ratio;
  assign preLast  = ({1'b0, aPre} + RW1'(1)) >= {1'b0, ratioEff};
  assign posLast  = ({1'b0, aPos} + W1'(1)) >= {1'b0, lenA};

  assign flg.aLast    = preLast && posLast;
  assign flg.dlyHit   = (aPre == '0) && (aPos == delayPt);
  assign flg.bLast    = ({1'b0, bPos} + W1'(1)) >= {1'b0, lenB};
  assign flg.holdDone = holdCnt >= holdoff;
  assign flg.idleDone = idleCnt >= autoTimeout;

  // timebase A prescaler and position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aPre <= '0;
      aPos <= '0;
    end else if (stb.aStart) begin
      aPre <= '0;
      aPos <= '0;
    end else if (stb.aAdv) begin
      if (preLast) begin
        aPre <= '0;
        if (!posLast) aPos <= aPos + W'(1);
      end else begin
        aPre <= aPre + RATIO_W'(1);
      end
    end
  end

  // timebase B position
  always_ff @(posedge clk) begin
    if (!rstN)                          bPos <= '0;
    else if (stb.bStart)                bPos <= '0;
    else if (stb.bAdv && !flg.bLast)    bPos <= bPos + W'(1);
  end

  // holdoff and free-run counters, both saturating at their limits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
      idleCnt <= '0;
    end else begin
      if (stb.holdClr)                          holdCnt <= '0;
      else if (stb.holdInc && !flg.holdDone)    holdCnt <= holdCnt + W'(1);
      if (stb.idleClr)                          idleCnt <= '0;
      else if (stb.idleInc && !flg.idleDone)    idleCnt <= idleCnt + W'(1);
    end
  end

endmodule

// File: rtl/sweep_ctl.sv
module sweep_ctl
  import sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigStb,
  input  logic       dlyTrigStb,
  input  logic       autoMode,
  input  logic       bStartSel,
  input  logic [1:0] dispMode,
  input  flag_t      flg,
  output strobe_t    stb,
  output logic       aSweep,
  output logic       bSweep,
  output logic       intensify,
  output logic       dispSel
);

  phase_e  phase, phaseNxt;
  bstate_e bState, bNxt;

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    bNxt     = bState;

    case (phase)
      PH_ARMED: begin
        if (trigStb || (autoMode && flg.idleDone)) begin
          phaseNxt   = PH_SWEEP;
          stb.aStart = 1'b1;
        end else begin
          stb.idleInc = 1'b1;
        end
      end
      PH_SWEEP: begin
        stb.aAdv = 1'b1;
        if (flg.aLast) begin
          phaseNxt    = PH_HOLD;
          stb.holdClr = 1'b1;
        end
      end
      PH_HOLD: begin
        if (bState != B_RUN) begin
          if (flg.holdDone) begin
            phaseNxt    = PH_ARMED;
            stb.idleClr = 1'b1;
          end else begin
            stb.holdInc = 1'b1;
          end
        end
      end
      default: phaseNxt = PH_ARMED;
    endcase

    case (bState)
      B_OFF: begin
        if (phase == PH_SWEEP && flg.dlyHit) begin
          if (bStartSel) begin
            bNxt = B_WAIT;
          end else begin
            bNxt       = B_RUN;
            stb.bStart = 1'b1;
          end
        end
      end
      B_WAIT: begin
        if (phase != PH_SWEEP) begin
          bNxt = B_OFF;
        end else if (dlyTrigStb) begin
          bNxt       = B_RUN;
          stb.bStart = 1'b1;
        end else if (flg.aLast) begin
          bNxt = B_OFF;
        end
      end
      B_RUN: begin
        stb.bAdv = 1'b1;
        if (flg.bLast) bNxt = B_OFF;
      end
      default: bNxt = B_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_ARMED;
      bState <= B_OFF;
    end else begin
      phase  <= phaseNxt;
      bState <= bNxt;
    end
  end

  assign aSweep = (phase == PH_SWEEP);
  assign bSweep = (bState == B_RUN);

  always_comb begin
    intensify = 1'b0;
    dispSel   = 1'b0;
    case (dmode_e'(dispMode))
      DM_INTENS: intensify = aSweep && bSweep;
      DM_B:      dispSel   = 1'b1;
      DM_MIX:    dispSel   = (bState != B_OFF);
      default:   dispSel   = 1'b0;
    endcase
  end

endmodule

// File: rtl/sweep_timebase.sv
module sweep_timebase
  import sweep_pkg::*;
#(
  parameter int W       = 16,
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigStb,
  input  logic               dlyTrigStb,
  input  logic               autoMode,
  input  logic               bStartSel,
  input  logic [1:0]         dispMode,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [W-1:0]       lenA,
  input  logic [W-1:0]       delayPt,
  input  logic [W-1:0]       lenB,
  input  logic [W-1:0]       holdoff,
  input  logic [W-1:0]       autoTimeout,
  output logic               aSweep,
  output logic               bSweep,
  output logic [W-1:0]       aPos,
  output logic [W-1:0]       bPos,
  output logic               intensify,
  output logic               dispSel
);

  strobe_t stb;
  flag_t   flg;

  sweep_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .trigStb    (trigStb),
    .dlyTrigStb (dlyTrigStb),
    .autoMode   (autoMode),
    .bStartSel  (bStartSel),
    .dispMode   (dispMode),
    .flg        (flg),
    .stb        (stb),
    .aSweep     (aSweep),
    .bSweep     (bSweep),
    .intensify  (intensify),
    .dispSel    (dispSel)
  );

  sweep_dp #(.W(W), .RATIO_W(RATIO_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ratio       (ratio),
    .lenA        (lenA),
    .delayPt     (delayPt),
    .lenB        (lenB),
    .holdoff     (holdoff),
    .autoTimeout (autoTimeout),
    .flg         (flg),
    .aPos        (aPos),
    .bPos        (bPos)
  );

endmodule

// File: rtl/sweep_timebase_chk.sv
module sweep_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         trigStb,
  input logic         autoMode,
  input logic [1:0]   dispMode,
  input logic         aSweep,
  input logic         bSweep,
  input logic [W-1:0] aPos,
  input logic [W-1:0] bPos,
  input logic         intensify,
  input logic         dispSel
);

  a_r2_normal_needs_trig: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(aSweep) && !$past(autoMode)) |-> $past(trigStb));

  a_r4_apos_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (aSweep && $past(aSweep)) |-> (aPos == $past(aPos) || aPos == $past(aPos) + W'(1)));

  a_r5_idle_after_sweep: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aSweep) |=> !aSweep);

  a_r6_b_starts_inside_a: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bSweep) |-> $past(aSweep));

  a_r9_bpos_step: assert property (@(posedge clk) disable iff (!rstN)
    (bSweep && $past(bSweep)) |-> (bPos == $past(bPos) + W'(1)));

  a_r9_no_rearm_during_b: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aSweep) |-> !$past(bSweep));

  a_r10_intensify_window: assert property (@(posedge clk) disable iff (!rstN)
    intensify |-> (aSweep && bSweep && dispMode == 2'd1));

  a_r11_select_a_modes: assert property (@(posedge clk) disable iff (!rstN)
    (dispMode == 2'd0 || dispMode == 2'd1) |-> !dispSel);

  a_r11_select_b_mode: assert property (@(posedge clk) disable iff (!rstN)
    (dispMode == 2'd2) |-> dispSel);

endmodule

bind sweep_timebase sweep_timebase_chk #(.W(W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .trigStb   (trigStb),
  .autoMode  (autoMode),
  .dispMode  (dispMode),
  .aSweep    (aSweep),
  .bSweep    (bSweep),
  .aPos      (aPos),
  .bPos      (bPos),
  .intensify (intensify),
  .dispSel   (dispSel)
);

// File: tb/tb_sweep_timebase.sv
module tb_sweep_timebase;

  localparam int  W          = 16;
  localparam int  RATIO_W    = 10;
  localparam time CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN;
  logic               trigStb, dlyTrigStb, autoMode, bStartSel;
  logic [1:0]         dispMode;
  logic [RATIO_W-1:0] ratio;
  logic [W-1:0]       lenA, delayPt, lenB, holdoff, autoTimeout;
  logic               aSweep, bSweep, intensify, dispSel;
  logic [W-1:0]       aPos, bPos;

  sweep_timebase #(.W(W), .RATIO_W(RATIO_W)) dut (
    .clk(clk), .rstN(rstN), .trigStb(trigStb), .dlyTrigStb(dlyTrigStb),
    .autoMode(autoMode), .bStartSel(bStartSel), .dispMode(dispMode),
    .ratio(ratio), .lenA(lenA), .delayPt(delayPt), .lenB(lenB),
    .holdoff(holdoff), .autoTimeout(autoTimeout),
    .aSweep(aSweep), .bSweep(bSweep), .aPos(aPos), .bPos(bPos),
    .intensify(intensify), .dispSel(dispSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  // episode configuration
  int cAuto, cSel, cMode, cRatio, cLenA, cDly, cLenB, cHold, cTo;
  // reference model state: phase 0 hold, 1 armed, 2 sweep; B 0 off, 1 wait, 2 run
  int mPh, mT, mB, mBc, mHold, mIdle;
  // observations per episode
  int aHighCnt, bHighCnt, firstLow, firstLen, aRunCur, bRunCur, bRunMax;
  bit seenA, firstDone;

  function automatic int rEff();
    return (cRatio == 0) ? 1 : cRatio;
  endfunction
  function automatic int laEff();
    return (cLenA == 0) ? 1 : cLenA;
  endfunction
  function automatic int lbEff();
    return (cLenB == 0) ? 1 : cLenB;
  endfunction

  task automatic check(string req, string nm, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compareOut();
    bit eA, eB, eInt, eSel;
    eA   = (mPh == 2);
    eB   = (mB == 2);
    eInt = (cMode == 1) && eA && eB;
    eSel = (cMode == 2) ? 1'b1 : (cMode == 3) ? (mB != 0) : 1'b0;
    check("R2/R3/R5", "aSweep", int'(aSweep), int'(eA));
    check("R6/R7/R8", "bSweep", int'(bSweep), int'(eB));
    check("R10", "intensify", int'(intensify), int'(eInt));
    check("R11", "dispSel", int'(dispSel), int'(eSel));
    if (eA) check("R4", "aPos", int'(aPos), mT / rEff());
    if (eB) check("R9", "bPos", int'(bPos), mBc);
  endtask

  task automatic modelStep(bit t, bit dt);
    int r = rEff();
    int la = laEff();
    int lb = lbEff();
    bit hit = (mPh == 2) && (cDly < la) && (mT == cDly * r);
    bit aEnd = (mPh == 2) && (mT == la * r - 1);
    int nPh = mPh, nT = mT, nHold = mHold, nIdle = mIdle, nB = mB, nBc = mBc;
    case (mPh)
      2: if (aEnd) begin nPh = 0; nHold = 0; end else nT = mT + 1;
      0: if (mB != 2) begin
           if (mHold >= cHold) begin nPh = 1; nIdle = 0; end else nHold = mHold + 1;
         end
      default: if (t || (cAuto != 0 && mIdle >= cTo)) begin nPh = 2; nT = 0; end
               else if (mIdle < cTo) nIdle = mIdle + 1;
    endcase
    case (mB)
      0: if (hit) begin nB = (cSel != 0) ? 1 : 2; nBc = 0; end
      1: if (mPh != 2) nB = 0;
         else if (dt) begin nB = 2; nBc = 0; end
         else if (aEnd) nB = 0;
      default: if (mBc >= lb - 1) nB = 0; else nBc = mBc + 1;
    endcase
    mPh = nPh; mT = nT; mHold = nHold; mIdle = nIdle; mB = nB; mBc = nBc;
  endtask

  task automatic startEpisode();
    autoMode    = (cAuto != 0);
    bStartSel   = (cSel != 0);
    dispMode    = 2'(cMode);
    ratio       = RATIO_W'(cRatio);
    lenA        = W'(cLenA);
    delayPt     = W'(cDly);
    lenB        = W'(cLenB);
    holdoff     = W'(cHold);
    autoTimeout = W'(cTo);
    trigStb = 0; dlyTrigStb = 0; rstN = 0;
    repeat (2) @(negedge clk);
    mPh = 1; mT = 0; mB = 0; mBc = 0; mHold = 0; mIdle = 0;
    check("R1", "aSweep in reset", int'(aSweep), 0);
    check("R1", "bSweep in reset", int'(bSweep), 0);
    check("R1", "intensify in reset", int'(intensify), 0);
    check("R1", "dispSel in reset", int'(dispSel), (cMode == 2) ? 1 : 0);
    aHighCnt = 0; bHighCnt = 0; firstLow = 0; firstLen = 0;
    aRunCur = 0; bRunCur = 0; bRunMax = 0; seenA = 0; firstDone = 0;
    rstN = 1;
  endtask

  // pT, pD: strobe probability per thousand; earlyOnly keeps dlyTrigStb at or before the delay point
  task automatic runEpisode(int cycles, int pT, int pD, bit earlyOnly);
    for (int c = 0; c < cycles; c++) begin
      bit t, dt;
      t  = ($urandom_range(999) < pT);
      dt = ($urandom_range(999) < pD);
      if (earlyOnly && mPh == 2 && mT > cDly * rEff()) dt = 0;
      trigStb = t; dlyTrigStb = dt;
      modelStep(t, dt);
      @(negedge clk);
      compareOut();
      if (aSweep) begin
        aHighCnt++; seenA = 1; aRunCur++;
      end else begin
        if (!seenA) firstLow++;
        if (seenA && !firstDone) begin firstDone = 1; firstLen = aRunCur; end
        aRunCur = 0;
      end
      if (bSweep) begin
        bHighCnt++; bRunCur++;
        if (bRunCur > bRunMax) bRunMax = bRunCur;
      end else bRunCur = 0;
    end
    trigStb = 0; dlyTrigStb = 0;
  endtask

  function automatic int pickRate();
    case ($urandom_range(2))
      0: return 0;
      1: return 20;
      default: return 200;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7301));
    rstN = 0;

    // R2: NORMAL mode without triggers stays in standby
    cAuto = 0; cSel = 0; cMode = 0; cRatio = 3; cLenA = 6; cDly = 2; cLenB = 5; cHold = 2; cTo = 3;
    startEpisode();
    runEpisode(400, 0, 0, 0);
    check("R2", "sweeps without trigger", aHighCnt, 0);

    // R3 and R4: AUTO free-run timing and sweep length
    cAuto = 1; cSel = 0; cMode = 1; cRatio = 3; cLenA = 5; cDly = 1; cLenB = 4; cHold = 1; cTo = 7;
    startEpisode();
    runEpisode(200, 0, 0, 0);
    check("R3", "idle cycles before free-run", firstLow, 7);
    check("R4", "first sweep length", firstLen, 15);

    // R7 and R8: early delayed triggers ignored, armed B dropped at sweep end
    cAuto = 0; cSel = 1; cMode = 3; cRatio = 4; cLenA = 6; cDly = 2; cLenB = 8; cHold = 1; cTo = 0;
    startEpisode();
    runEpisode(1500, 100, 300, 1);
    check("R7/R8", "B cycles with only early delayed triggers", bHighCnt, 0);

    // R6: delay point beyond the sweep never starts B
    cAuto = 1; cSel = 0; cMode = 3; cRatio = 2; cLenA = 5; cDly = 8; cLenB = 6; cHold = 0; cTo = 2;
    startEpisode();
    runEpisode(600, 30, 0, 0);
    check("R6", "B cycles with delay past end", bHighCnt, 0);

    // R4: largest ratio
    cAuto = 1; cSel = 0; cMode = 1; cRatio = 1000; cLenA = 3; cDly = 1; cLenB = 50; cHold = 0; cTo = 0;
    startEpisode();
    runEpisode(8000, 0, 0, 0);
    check("R4", "sweep length at ratio 1000", firstLen, 3000);

    // R9: B outlives A and holds off re-arming
    cAuto = 1; cSel = 0; cMode = 2; cRatio = 2; cLenA = 2; cDly = 1; cLenB = 30; cHold = 0; cTo = 0;
    startEpisode();
    runEpisode(300, 50, 0, 0);
    check("R9", "longest B run", bRunMax, 30);

    // random episodes
    for (int e = 0; e < 14; e++) begin
      cAuto = $urandom_range(1); cSel = $urandom_range(1); cMode = $urandom_range(3);
      cRatio = $urandom_range(12); cLenA = $urandom_range(12); cDly = $urandom_range(14);
      cLenB = $urandom_range(40); cHold = $urandom_range(5); cTo = $urandom_range(30);
      startEpisode();
      runEpisode(2000, pickRate(), pickRate(), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    done = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog R1-to-R11 run actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule